// File: doc/BRIEF.md
# Single-Cycle Subset Processor Core

This block is a 32-bit load/store processor core that retires one instruction on every rising clock edge. In the same cycle it fetches the word at the program counter, splits it into fields, reads two registers, runs the ALU and, for loads, reads data memory. It then writes the result back and picks the next program counter.

The core is built for a nine-instruction subset: four arithmetic and logic operations, a signed compare-and-set, word load, word store, branch-on-equal and an absolute jump. Instruction and data memory sit outside the core as plain combinational-read arrays. Data memory is written on the clock edge whenever the core raises its write strobe.

The register file has 32 entries of 32 bits. Entry 0 always reads as zero. The ALU takes its second operand from register read port 2 or from the sign-extended 16-bit immediate. The write-back value comes from the ALU or from data memory. The destination index comes from the rd field or from the rt field.

Top module: `scp_core`

## Requirements
- R1: While rst_n is low, the program counter is held at 0, so imem_addr reads 0 and the register file reads all zeros.
- R2: Every instruction other than a taken branch or a jump advances the program counter by 4.
- R3: Opcode 0x00 selects a register operation by funct: 0x20 add, 0x22 subtract, 0x24 bitwise and, 0x25 bitwise or. The result R[rs] op R[rt] is written to R[rd], the field at bits 15:11.
- R4: Opcode 0x00 with funct 0x2A writes 1 to R[rd] when R[rs] < R[rt] as signed two's-complement values, and 0 otherwise.
- R5: Opcode 0x23 (load) drives dmem_addr with R[rs] plus the sign-extended bits 15:0, and writes dmem_rdata to R[rt], the field at bits 20:16.
- R6: Opcode 0x2B (store) drives dmem_addr as for a load, drives dmem_wdata with R[rt] and raises dmem_we. No other instruction raises dmem_we.
- R7: Opcode 0x04 (branch) compares R[rs] with R[rt]. When they are equal, the next program counter is PC+4 plus the sign-extended offset shifted left by 2. Otherwise it is PC+4.
- R8: Opcode 0x02 (jump) loads the program counter with bits 31:28 of PC+4, followed by bits 25:0 of the instruction, followed by two zero bits.
- R9: Register 0 always reads as zero. Any write aimed at it is discarded.
- R10: Any other opcode, and any funct outside R3/R4 under opcode 0x00, writes neither registers nor memory and advances the program counter by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Byte address of the instruction being executed (the program counter) |
| imem_data | input | 32 | Instruction word read combinationally at imem_addr |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Data memory write strobe, sampled at the rising edge |
| dmem_rdata | input | 32 | Load data read combinationally at dmem_addr |

## Verification
Register read and register write-back can name the same register in one instruction. The read then has to see the value from before the edge, and the write has to land on the edge. The bench draws most register fields from the low eight indices, and it includes a directed `add r2,r2,r2`, so sources and destination often coincide, and some of those writes target register 0. A reference model in the bench keeps its own register copy. That copy is compared indirectly: every later store's data and address, and every branch decision, seen as the next fetch address, must match it cycle by cycle.

// File: rtl/scp_pkg.sv
package scp_pkg;

  localparam int XLEN    = 32;
  localparam int RIDX_W  = 5;
  localparam int IMM_W   = 16;
  localparam int JADDR_W = 26;
  localparam int OP_W    = 6;

  localparam logic [OP_W-1:0] OP_REG    = 6'h00;
  localparam logic [OP_W-1:0] OP_JUMP   = 6'h02;
  localparam logic [OP_W-1:0] OP_BRANCH = 6'h04;
  localparam logic [OP_W-1:0] OP_LOAD   = 6'h23;
  localparam logic [OP_W-1:0] OP_STORE  = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  typedef struct packed {
    logic    reg_write;
    logic    dst_is_rd;
    logic    alu_use_imm;
    logic    wb_from_mem;
    logic    mem_write;
    logic    is_branch;
    logic    is_jump;
    alu_op_e alu_op;
  } ctrl_t;

  function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] v);
    return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input alu_op_e op,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    logic [XLEN-1:0] r;
    case (op)
      ALU_AND: r = a & b;
      ALU_OR:  r = a | b;
      ALU_ADD: r = a + b;
      ALU_SUB: r = a - b;
      ALU_SLT: r = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [XLEN-1:0] branch_dest(input logic [XLEN-1:0] seq_pc,
                                                  input logic [IMM_W-1:0] off);
    logic [XLEN-1:0] ext;
    ext = sext_imm(off);
    return seq_pc + {ext[XLEN-3:0], 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] jump_dest(input logic [XLEN-1:0] seq_pc,
                                                input logic [JADDR_W-1:0] tgt);
    return {seq_pc[XLEN-1:JADDR_W+2], tgt, 2'b00};
  endfunction

endpackage

// File: rtl/scp_decode.sv
module scp_decode
  import scp_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic [5:0]      funct,
  output ctrl_t           ctrl
);

  always_comb begin
    ctrl.reg_write   = 1'b0;
    ctrl.dst_is_rd   = 1'b0;
    ctrl.alu_use_imm = 1'b0;
    ctrl.wb_from_mem = 1'b0;
    ctrl.mem_write   = 1'b0;
    ctrl.is_branch   = 1'b0;
    ctrl.is_jump     = 1'b0;
    ctrl.alu_op      = ALU_ADD;
    case (op)
      OP_REG: begin
        ctrl.dst_is_rd = 1'b1;
        ctrl.reg_write = 1'b1;
        case (funct)
          FN_ADD:  ctrl.alu_op = ALU_ADD;
          FN_SUB:  ctrl.alu_op = ALU_SUB;
          FN_AND:  ctrl.alu_op = ALU_AND;
          FN_OR:   ctrl.alu_op = ALU_OR;
          FN_SLT:  ctrl.alu_op = ALU_SLT;
          default: ctrl.reg_write = 1'b0;
        endcase
      end
      OP_LOAD: begin
        ctrl.reg_write   = 1'b1;
        ctrl.alu_use_imm = 1'b1;
        ctrl.wb_from_mem = 1'b1;
      end
      OP_STORE: begin
        ctrl.alu_use_imm = 1'b1;
        ctrl.mem_write   = 1'b1;
      end
      OP_BRANCH: begin
        ctrl.is_branch = 1'b1;
        ctrl.alu_op    = ALU_SUB;
      end
      OP_JUMP: ctrl.is_jump = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/scp_alu.sv
module scp_alu
  import scp_pkg::*;
#(
  parameter int W = XLEN
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         zero
);

  always_comb begin
    y    = alu_eval(op, a, b);
    zero = (y == '0);
  end

endmodule

// File: rtl/scp_regfile.sv
module scp_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);

  logic [W-1:0] regs [NREG];
  logic         wr_hit_zero;

  assign wr_hit_zero = we && (wa == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && !wr_hit_zero) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];

  // R9
  r0_port1_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ra1 == '0) |-> (rd1 == '0));

  // R9
  r0_port2_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ra2 == '0) |-> (rd2 == '0));

endmodule

// File: rtl/scp_core.sv
module scp_core
  import scp_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_data,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata
);

  logic [XLEN-1:0]    pc_q, pc_next, pc_plus4, br_target, j_target;
  logic [OP_W-1:0]    f_op;
  logic [RIDX_W-1:0]  f_rs, f_rt, f_rd, wb_idx;
  logic [5:0]         f_funct;
  logic [IMM_W-1:0]   f_imm;
  logic [JADDR_W-1:0] f_jaddr;
  ctrl_t              ctrl;
  logic [XLEN-1:0]    rs_val, rt_val, imm_ext, alu_b, alu_y, wb_data;
  logic               alu_zero;
  logic               take_branch, seq_step;

  // field split
  assign f_op    = imem_data[31:26];
  assign f_rs    = imem_data[25:21];
  assign f_rt    = imem_data[20:16];
  assign f_rd    = imem_data[15:11];
  assign f_funct = imem_data[5:0];
  assign f_imm   = imem_data[15:0];
  assign f_jaddr = imem_data[25:0];

  scp_decode u_dec (
    .op    (f_op),
    .funct (f_funct),
    .ctrl  (ctrl)
  );

  scp_regfile #(.NREG(32), .W(XLEN)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .ra1   (f_rs),
    .ra2   (f_rt),
    .rd1   (rs_val),
    .rd2   (rt_val),
    .we    (ctrl.reg_write),
    .wa    (wb_idx),
    .wd    (wb_data)
  );

  assign imm_ext = sext_imm(f_imm);
  assign alu_b   = ctrl.alu_use_imm ? imm_ext : rt_val;

  scp_alu #(.W(XLEN)) u_alu (
    .op   (ctrl.alu_op),
    .a    (rs_val),
    .b    (alu_b),
    .y    (alu_y),
    .zero (alu_zero)
  );

  assign wb_idx  = ctrl.dst_is_rd ? f_rd : f_rt;
  assign wb_data = ctrl.wb_from_mem ? dmem_rdata : alu_y;

  // data memory side
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctrl.mem_write;

  // next PC
  assign pc_plus4    = pc_q + 32'd4;
  assign br_target   = branch_dest(pc_plus4, f_imm);
  assign j_target    = jump_dest(pc_plus4, f_jaddr);
  assign take_branch = ctrl.is_branch && alu_zero;
  assign seq_step    = !take_branch && !ctrl.is_jump;

  always_comb begin
    if (ctrl.is_jump)  pc_next = j_target;
    else if (take_branch) pc_next = br_target;
    else pc_next = pc_plus4;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= RESET_PC;
    else        pc_q <= pc_next;
  end

  assign imem_addr = pc_q;

  // R1
  reset_pc_chk: assert property (@(posedge clk)
    !rst_n |=> (imem_addr == RESET_PC));

  // R2
  seq_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_step |=> (imem_addr == $past(imem_addr) + 32'd4));

  // R7
  branch_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.is_branch && (rs_val == rt_val)) |=> (imem_addr == $past(br_target)));

  // R7
  branch_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.is_branch && (rs_val != rt_val)) |=> (imem_addr == $past(imem_addr) + 32'd4));

  // R8
  jump_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (f_op == OP_JUMP) |=> (imem_addr[1:0] == 2'b00 &&
                           imem_addr[31:28] == $past(pc_plus4[31:28])));

  // R6
  store_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> (imem_data[31:26] == OP_STORE));

  // R4
  slt_bool_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (f_op == OP_REG && f_funct == FN_SLT) |-> (wb_data[31:1] == '0));

  // R10
  undef_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (f_op != OP_REG && f_op != OP_LOAD && f_op != OP_STORE &&
     f_op != OP_BRANCH && f_op != OP_JUMP) |-> (!dmem_we && !ctrl.reg_write));

endmodule

// File: tb/scp_core_test.sv
module scp_core_test;

  localparam int MWORDS = 256;
  localparam int NCYC   = 3000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  logic [31:0] imem [MWORDS];
  logic [31:0] dmem [MWORDS];

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // bench reference state
  logic [31:0] m_regs [32];
  string       m_tag  [32];
  logic [31:0] m_pc;
  string       prev_tag;

  always #10 clk = ~clk;

  assign imem_data  = imem[imem_addr[9:2]];
  assign dmem_rdata = dmem[dmem_addr[9:2]];

  always @(posedge clk) if (dmem_we) dmem[dmem_addr[9:2]] <= dmem_wdata;

  scp_core uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_data  (imem_data),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata)
  );

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, rs[4:0], rt[4:0], imm};
  endfunction

  function automatic logic [31:0] sx(input logic [15:0] v);
    return 32'($signed(v));
  endfunction

  function automatic logic [31:0] ref_op(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b);
    case (fn)
      6'h20: return a + b;
      6'h22: return a - b;
      6'h24: return a & b;
      6'h25: return a | b;
      default: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
    endcase
  endfunction

  function automatic int pick_reg();
    return ($urandom % 4 == 0) ? int'($urandom % 32) : int'($urandom % 8);
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step_model();
    logic [31:0] ins, a, b, addr, res, p4;
    logic [5:0]  op, fn;
    int rs, rt, rd;
    ins = imem[m_pc[9:2]];
    op = ins[31:26]; fn = ins[5:0];
    rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
    a = m_regs[rs]; b = m_regs[rt];
    p4 = m_pc + 32'd4;
    chk(imem_addr, m_pc, prev_tag, "fetch address");
    chk({31'd0, dmem_we}, {31'd0, (op == 6'h2B)}, "R6", "write strobe");
    addr = a + sx(ins[15:0]);
    m_pc = p4;
    prev_tag = "R2";
    case (op)
      6'h00: begin
        if (fn == 6'h20 || fn == 6'h22 || fn == 6'h24 || fn == 6'h25 || fn == 6'h2A) begin
          res = ref_op(fn, a, b);
          if (rd != 0) begin
            m_regs[rd] = res;
            m_tag[rd] = (fn == 6'h2A) ? "R4" : "R3";
          end
        end else prev_tag = "R10";
      end
      6'h23: begin
        chk(dmem_addr, addr, "R5", "load address");
        if (rt != 0) begin
          m_regs[rt] = dmem[addr[9:2]];
          m_tag[rt] = "R5";
        end
      end
      6'h2B: begin
        chk(dmem_addr, addr, "R6", "store address");
        chk(dmem_wdata, b, m_tag[rt], "store data");
      end
      6'h04: begin
        if (a == b) m_pc = p4 + {sx(ins[15:0]), 2'b00}; // R7
        prev_tag = "R7";
      end
      6'h02: begin
        m_pc = {p4[31:28], ins[25:0], 2'b00}; // R8
        prev_tag = "R8";
      end
      default: prev_tag = "R10";
    endcase
  endtask

  task automatic build_program();
    // directed corners
    dmem[0] = 32'h8000_0000;
    dmem[1] = 32'h0000_0001;
    imem[0]  = enc_i(6'h23, 0, 1, 16'h0000);  // load r1 (R5)
    imem[1]  = enc_i(6'h23, 0, 2, 16'h0004);  // load r2
    imem[2]  = enc_r(1, 2, 3, 6'h2A);         // slt negative < 1 -> 1 (R4)
    imem[3]  = enc_r(2, 1, 4, 6'h2A);         // slt -> 0 (R4)
    imem[4]  = enc_r(1, 2, 0, 6'h20);         // write to r0 discarded (R9)
    imem[5]  = enc_i(6'h2B, 0, 3, 16'h0008);
    imem[6]  = enc_i(6'h2B, 0, 4, 16'h000C);
    imem[7]  = enc_i(6'h2B, 0, 0, 16'h0010);
    imem[8]  = enc_r(2, 2, 2, 6'h20);         // same register read and written (R3)
    imem[9]  = enc_i(6'h04, 1, 1, 16'h0001);  // taken branch skips 10 (R7)
    imem[10] = enc_i(6'h2B, 0, 1, 16'hFFFC);
    imem[11] = enc_i(6'h2B, 0, 2, 16'hFFFC);  // negative offset (R6)
    imem[12] = {6'h02, 26'd14};               // jump over 13 (R8)
    imem[13] = 32'hFC00_0000;
    for (int i = 14; i < MWORDS; i++) begin
      int k;
      k = int'($urandom % 100);
      if (k < 40) begin
        logic [5:0] fn;
        case ($urandom % 5)
          0: fn = 6'h20; 1: fn = 6'h22; 2: fn = 6'h24; 3: fn = 6'h25; default: fn = 6'h2A;
        endcase
        imem[i] = enc_r(pick_reg(), pick_reg(), pick_reg(), fn);
      end else if (k < 55) begin
        imem[i] = enc_i(6'h23, pick_reg(), pick_reg(), 16'($urandom));
      end else if (k < 72) begin
        imem[i] = enc_i(6'h2B, pick_reg(), pick_reg(), 16'($urandom));
      end else if (k < 88) begin
        int o;
        o = int'($urandom % 16) - 6;
        if (o == -1) o = 3;
        imem[i] = enc_i(6'h04, pick_reg(), pick_reg(), 16'(o));
      end else if (k < 94) begin
        imem[i] = {6'h02, 26'($urandom)};
      end else if (k < 97) begin
        imem[i] = enc_r(pick_reg(), pick_reg(), pick_reg(), 6'h3F);
      end else begin
        imem[i] = {6'h3F, 26'($urandom)};
      end
    end
    for (int i = 2; i < MWORDS; i++) dmem[i] = $urandom;
  endtask

  initial begin
    void'($urandom(32'd7919));
    build_program();
    for (int i = 0; i < 32; i++) begin
      m_regs[i] = '0;
      m_tag[i] = (i == 0) ? "R9" : "R1";
    end
    m_pc = '0;
    prev_tag = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(imem_addr, 32'h0, "R1", "pc under reset");
    chk({31'd0, dmem_we}, 32'd0, "R1", "no store under reset");
    rst_n = 1'b1;
    for (int c = 0; c < NCYC; c++) begin
      #1;
      step_model();
      @(negedge clk);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * (NCYC + 500));
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule